// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 256-byte configuration space of a simple bus target that uses the general-device header layout (header type 00h). Host software reaches it through a dword-indexed port: a 6-bit dword index, four byte-lane enables, a write strobe, 32-bit write data and 32-bit read data. The port works in every cycle after reset. Reads are combinational from the index and the lane enables. Writes take effect at the rising clock edge.

The block stores the command register, the error half of the status register and one 32-bit memory base address register. The identification, revision, class and header-type fields are fixed by parameters. The decode enables and the programmed base address go out to the target logic next to it. Event pulses from that logic set sticky error flags, and software clears them by writing ones. Every other location in the space, including the device-specific area from byte 40h up, reads as zero and ignores writes. Software can therefore probe any offset safely. Both decoders come out of reset disabled, so the target answers no address until software has placed it.

Top module: `cfg_hdr_regs`

## Requirements
- R1: After reset the command register reads 0000h, all status error flags read 0, the base register reads 0, and `mem_en` and `io_en` are low.
- R2: Dword 0 reads with the vendor ID in bits 15:0 and the device ID in bits 31:16 (lowest byte address = least significant byte). Writes to it change nothing.
- R3: Dword 2 reads {class code, revision ID}. Dword 3 reads all zero, so the header-type byte at byte offset 0Eh (bits 23:16) is 00h. Writes to either change nothing.
- R4: Command bits 0 (I/O decode), 1 (memory decode), 2 (bus master), 6 (parity response) and 8 (system-error report) are writable. All other command bits read 0. `io_en` follows bit 0 and `mem_en` follows bit 1 from the cycle after the write.
- R5: Lane enable k covers bits 8k+7:8k. A write changes only the enabled bytes, and a read returns zero in every disabled byte.
- R6: Event input bits 5,4,3,2,1,0 set the status flags at dword-1 bits 31,30,29,28,27,24. A write of 1 to a flag with lane 3 enabled clears it. Writing 0 leaves it unchanged. An event in the same cycle as a clear leaves the flag set. All other status bits read 0.
- R7: The base register at dword 4 has bits BAR_SZ_LOG2-1:0 hardwired to 0, which makes the memory-type bits 3:0 read 0. After writing FFFFFFFFh it reads back the size mask (FFFFF000h at the default 4 KB). `mem_base` equals the stored value.
- R8: Dwords 5 to 15 (unimplemented header registers) and 16 to 63 (device-specific area from 40h) read zero. Writes to them change no implemented register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_idx | input | 6 | Dword index into the 256-byte space |
| cfg_be | input | 4 | Byte-lane enables, bit k for bits 8k+7:8k |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_idx, masked by cfg_be |
| err_evt | input | 6 | Error event pulses that set the sticky status flags |
| mem_en | output | 1 | Memory-space decode enable |
| io_en | output | 1 | I/O-space decode enable |
| mem_base | output | 32 | Programmed memory base address |

## Verification
The bench sizes the base register with an all-ones write. A design that let the low bits through would return a wrong size and report a prefetchable or 64-bit type. It writes zeros, then ones, to the error flags, and raises an event in the same cycle as a clear. A design with plain writable flags, or one that gives the clear priority, would lose an error record. Partial-lane writes and reads check that a byte outside the enables is neither written nor returned. Writes of all ones to reserved header and device-specific dwords must leave the command and base registers intact and read back zero, which catches a decoder that aliases higher indices onto the header.

// File: rtl/cfg_hdr_pkg.sv
// Shared constants and helpers for the configuration header register file.
// Assumes a 256-byte space addressed as 64 dwords.
package cfg_hdr_pkg;

    localparam int          IDX_W       = 6;
    localparam int          ERR_N       = 6;

    // Dword indices of the implemented header locations
    localparam logic [IDX_W-1:0] IDX_IDENT   = 6'd0;
    localparam logic [IDX_W-1:0] IDX_CMDSTAT = 6'd1;
    localparam logic [IDX_W-1:0] IDX_CLASS   = 6'd2;
    localparam logic [IDX_W-1:0] IDX_MISC    = 6'd3;
    localparam logic [IDX_W-1:0] IDX_BAR     = 6'd4;

    // Writable command bits: I/O, memory, master, parity response, system-error report
    localparam logic [15:0] CMD_RW_MASK = 16'h0147;

    // Expand four lane enables into a 32-bit byte mask
    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int k = 0; k < 4; k++) begin
            m[8*k +: 8] = {8{be[k]}};
        end
        return m;
    endfunction

    // Place the sticky flags into the upper status half (dword bits 31:16)
    function automatic logic [15:0] err_to_stat(input logic [ERR_N-1:0] e);
        return {e[5], e[4], e[3], e[2], e[1], 2'b00, e[0], 8'h00};
    endfunction

    // Pick the flag positions out of the top status byte (dword bits 31:24)
    function automatic logic [ERR_N-1:0] stat_byte_to_err(input logic [7:0] b);
        return {b[7], b[6], b[5], b[4], b[3], b[0]};
    endfunction

endpackage

// File: rtl/cfg_cmd_stat.sv
// Command register and sticky error flags of the status register.
// Assumes the top has already qualified the write strobes by index.
// Command bits outside CMD_RW_MASK are never stored. A flag set by an event
// wins over a write-one clear in the same cycle.
module cfg_cmd_stat
    import cfg_hdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [1:0]       cmd_lanes,
    input  logic [15:0]      cmd_wd,
    input  logic             stat_we,
    input  logic [7:0]       stat_wd,
    input  logic [ERR_N-1:0] err_evt,
    output logic [15:0]      cmd_q,
    output logic [ERR_N-1:0] err_q
);

    logic [ERR_N-1:0] err_clr;

    // One byte of the command register per lane
    for (genvar g = 0; g < 2; g++) begin : g_cmd_lane
        localparam logic [7:0] RW = CMD_RW_MASK[8*g +: 8];

        // Update the writable bits of this lane and clear them on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmd_q[8*g +: 8] <= 8'h00;
            end else if (cmd_we && cmd_lanes[g]) begin
                cmd_q[8*g +: 8] <= cmd_wd[8*g +: 8] & RW;
            end
        end
    end

    // Ones written to the top status byte select flags to clear
    always_comb begin
        err_clr = stat_we ? stat_byte_to_err(stat_wd) : '0;
    end

    // Sticky flags: events set, write-one clears, set takes priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= (err_q & ~err_clr) | err_evt;
        end
    end

endmodule

// File: rtl/cfg_bar_reg.sv
// Single 32-bit memory base address register with size masking.
// Assumes BAR_SZ_LOG2 lies between 4 and 31. Bits below BAR_SZ_LOG2 are
// hardwired to zero, so software sizes the window by writing all ones.
// The memory-type bits always read as 32-bit, non-prefetchable memory.
module cfg_bar_reg #(
    parameter int BAR_SZ_LOG2 = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bar_we,
    input  logic [3:0]  bar_lanes,
    input  logic [31:0] bar_wd,
    output logic [31:0] bar_q
);

    localparam logic [31:0] SIZE_MASK = ~((32'd1 << BAR_SZ_LOG2) - 32'd1);

    // One byte of the base register per lane
    for (genvar g = 0; g < 4; g++) begin : g_bar_lane
        localparam logic [7:0] RW = SIZE_MASK[8*g +: 8];

        // Load the address bits of this lane, keep the size bits at zero
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bar_q[8*g +: 8] <= 8'h00;
            end else if (bar_we && bar_lanes[g]) begin
                bar_q[8*g +: 8] <= bar_wd[8*g +: 8] & RW;
            end
        end
    end

endmodule

// File: rtl/cfg_rd_mux.sv
// Read-side decode of the configuration space.
// Assumes a combinational read. Fixed fields come from parameters.
// Every index not listed reads zero. Disabled lanes return zero bytes.
module cfg_rd_mux
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VEN_ID     = 16'h1D5A,
    parameter logic [15:0] DEV_ID     = 16'h0C21,
    parameter logic [7:0]  REV_ID     = 8'h03,
    parameter logic [23:0] CLASS_CODE = 24'h118000
) (
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [3:0]       rd_lanes,
    input  logic [15:0]      cmd_q,
    input  logic [ERR_N-1:0] err_q,
    input  logic [31:0]      bar_q,
    output logic [31:0]      rd_data
);

    logic [31:0] raw;

    // Select the dword, then blank the lanes not enabled
    always_comb begin
        unique case (rd_idx)
            IDX_IDENT:   raw = {DEV_ID, VEN_ID};
            IDX_CMDSTAT: raw = {err_to_stat(err_q), cmd_q};
            IDX_CLASS:   raw = {CLASS_CODE, REV_ID};
            IDX_MISC:    raw = 32'h0000_0000;
            IDX_BAR:     raw = bar_q;
            default:     raw = 32'h0000_0000;
        endcase
        rd_data = raw & lane_mask(rd_lanes);
    end

endmodule

// File: rtl/cfg_hdr_regs.sv
// Top of the configuration header register file.
// Decodes the dword index for writes, holds the command, status and base
// registers, and exports the decode enables and the base address.
// Assumes VEN_ID is not FFFFh, which would mark an absent device.
module cfg_hdr_regs
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VEN_ID      = 16'h1D5A,
    parameter logic [15:0] DEV_ID      = 16'h0C21,
    parameter logic [7:0]  REV_ID      = 8'h03,
    parameter logic [23:0] CLASS_CODE  = 24'h118000,
    parameter int          BAR_SZ_LOG2 = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  cfg_idx,
    input  logic [3:0]  cfg_be,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [5:0]  err_evt,
    output logic        mem_en,
    output logic        io_en,
    output logic [31:0] mem_base
);

    logic             cs_we;
    logic             bar_we;
    logic [15:0]      cmd_q;
    logic [ERR_N-1:0] err_q;
    logic [31:0]      bar_q;

    // Write strobes per implemented dword; all other indices drop the data
    always_comb begin
        cs_we  = cfg_we && (cfg_idx == IDX_CMDSTAT);
        bar_we = cfg_we && (cfg_idx == IDX_BAR);
    end

    cfg_cmd_stat u_cmd_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cs_we),
        .cmd_lanes (cfg_be[1:0]),
        .cmd_wd    (cfg_wdata[15:0]),
        .stat_we   (cs_we && cfg_be[3]),
        .stat_wd   (cfg_wdata[31:24]),
        .err_evt   (err_evt),
        .cmd_q     (cmd_q),
        .err_q     (err_q)
    );

    cfg_bar_reg #(
        .BAR_SZ_LOG2 (BAR_SZ_LOG2)
    ) u_bar (
        .clk       (clk),
        .rst_n     (rst_n),
        .bar_we    (bar_we),
        .bar_lanes (cfg_be),
        .bar_wd    (cfg_wdata),
        .bar_q     (bar_q)
    );

    cfg_rd_mux #(
        .VEN_ID     (VEN_ID),
        .DEV_ID     (DEV_ID),
        .REV_ID     (REV_ID),
        .CLASS_CODE (CLASS_CODE)
    ) u_rd_mux (
        .rd_idx   (cfg_idx),
        .rd_lanes (cfg_be),
        .cmd_q    (cmd_q),
        .err_q    (err_q),
        .bar_q    (bar_q),
        .rd_data  (cfg_rdata)
    );

    // Outputs to the target logic
    always_comb begin
        io_en    = cmd_q[0];
        mem_en   = cmd_q[1];
        mem_base = bar_q;
    end

endmodule

// File: rtl/cfg_hdr_regs_chk.sv
// Property checker for cfg_hdr_regs, attached by the bind at the end.
// Assumes it observes the top-level ports and the internal flag vector.
module cfg_hdr_regs_chk
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VEN_ID      = 16'h1D5A,
    parameter logic [15:0] DEV_ID      = 16'h0C21,
    parameter int          BAR_SZ_LOG2 = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [5:0]       cfg_idx,
    input logic [3:0]       cfg_be,
    input logic             cfg_we,
    input logic [31:0]      cfg_wdata,
    input logic [31:0]      cfg_rdata,
    input logic [5:0]       err_evt,
    input logic             mem_en,
    input logic             io_en,
    input logic [31:0]      mem_base,
    input logic [ERR_N-1:0] err_q
);

    assert_id_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == IDX_IDENT && cfg_be == 4'hF) |-> cfg_rdata == {DEV_ID, VEN_ID});

    assert_misc_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == IDX_MISC) |-> cfg_rdata == 32'h0);

    assert_mem_en_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_en) |-> $past(cfg_we && cfg_idx == IDX_CMDSTAT && cfg_be[0] && cfg_wdata[1]));

    assert_io_en_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_en) |-> $past(cfg_we && cfg_idx == IDX_CMDSTAT && cfg_be[0] && cfg_wdata[0]));

    assert_lane_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~lane_mask(cfg_be)) == 32'h0);

    assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_evt) |=> ((err_q & $past(err_evt)) == $past(err_evt)));

    assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt == '0 && !(cfg_we && cfg_idx == IDX_CMDSTAT && cfg_be[3])) |=> $stable(err_q));

    assert_bar_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_base[BAR_SZ_LOG2-1:0] == '0);

    assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx > IDX_BAR) |-> cfg_rdata == 32'h0);

    assert_bar_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_idx == IDX_BAR) |=> $stable(mem_base));

endmodule

bind cfg_hdr_regs cfg_hdr_regs_chk #(
    .VEN_ID      (VEN_ID),
    .DEV_ID      (DEV_ID),
    .BAR_SZ_LOG2 (BAR_SZ_LOG2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_idx   (cfg_idx),
    .cfg_be    (cfg_be),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .err_evt   (err_evt),
    .mem_en    (mem_en),
    .io_en     (io_en),
    .mem_base  (mem_base),
    .err_q     (err_q)
);

// File: tb/cfg_hdr_regs_tb_top.sv
`timescale 1ns/1ps
// Bench for cfg_hdr_regs: directed corner cases, then seeded random traffic,
// compared against a reference model kept in bench variables.
module cfg_hdr_regs_tb_top;

    localparam logic [15:0] VEN  = 16'h1D5A;
    localparam logic [15:0] DEV  = 16'h0C21;
    localparam logic [7:0]  REV  = 8'h03;
    localparam logic [23:0] CLS  = 24'h118000;
    localparam int          SZ   = 12;
    localparam logic [31:0] SZ_MASK = ~((32'd1 << SZ) - 32'd1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_idx = '0;
    logic [3:0]  cfg_be = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [5:0]  err_evt = '0;
    logic        mem_en, io_en;
    logic [31:0] mem_base;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model
    logic [15:0] m_cmd = '0;
    logic [5:0]  m_err = '0;
    logic [31:0] m_bar = '0;

    always #4 clk = ~clk;

    cfg_hdr_regs #(
        .VEN_ID (VEN), .DEV_ID (DEV), .REV_ID (REV),
        .CLASS_CODE (CLS), .BAR_SZ_LOG2 (SZ)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_idx (cfg_idx), .cfg_be (cfg_be),
        .cfg_we (cfg_we), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .err_evt (err_evt), .mem_en (mem_en), .io_en (io_en), .mem_base (mem_base)
    );

    function automatic logic [31:0] bmask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    // Status flags at bits 31,30,29,28,27,24 of dword 1 (R6)
    function automatic logic [15:0] stat_hi(input logic [5:0] e);
        logic [15:0] s;
        s = '0;
        s[15] = e[5]; s[14] = e[4]; s[13] = e[3];
        s[12] = e[2]; s[11] = e[1]; s[8]  = e[0];
        return s;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [5:0] idx, input logic [3:0] be);
        logic [31:0] v;
        case (idx)
            6'd0:    v = {DEV, VEN};
            6'd1:    v = {stat_hi(m_err), m_cmd};
            6'd2:    v = {CLS, REV};
            6'd4:    v = m_bar;
            default: v = 32'h0;
        endcase
        return v & bmask(be);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Apply the model effect of one clock edge
    task automatic model_edge(input logic we, input logic [5:0] idx, input logic [3:0] be,
                              input logic [31:0] wd, input logic [5:0] evt);
        logic [31:0] m;
        logic [5:0]  clr;
        m = bmask(be);
        clr = '0;
        if (we && idx == 6'd1) begin
            m_cmd = (m_cmd & ~(m[15:0] & 16'h0147)) | (wd[15:0] & m[15:0] & 16'h0147);
            if (be[3]) clr = {wd[31], wd[30], wd[29], wd[28], wd[27], wd[24]};
        end
        if (we && idx == 6'd4)
            m_bar = ((m_bar & ~m) | (wd & m)) & SZ_MASK;
        m_err = (m_err & ~clr) | evt;
    endtask

    // One clock with the given inputs, then check the outputs
    task automatic cyc(input logic we, input logic [5:0] idx, input logic [3:0] be,
                       input logic [31:0] wd, input logic [5:0] evt, input string tag);
        @(negedge clk);
        cfg_we = we; cfg_idx = idx; cfg_be = be; cfg_wdata = wd; err_evt = evt;
        @(posedge clk);
        model_edge(we, idx, be, wd, evt);
        @(negedge clk);
        cfg_we = 1'b0; err_evt = '0;
        #1;
        check({tag, " mem_en"}, {31'd0, mem_en}, {31'd0, m_cmd[1]});
        check({tag, " io_en"},  {31'd0, io_en},  {31'd0, m_cmd[0]});
        check({tag, " mem_base"}, mem_base, m_bar);
    endtask

    task automatic rd(input logic [5:0] idx, input logic [3:0] be, input string tag);
        @(negedge clk);
        cfg_we = 1'b0; cfg_idx = idx; cfg_be = be; err_evt = '0;
        #1;
        check(tag, cfg_rdata, exp_rd(idx, be));
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h00C0FFEE);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        #1;
        check("R1 mem_en", {31'd0, mem_en}, 32'd0);
        check("R1 io_en", {31'd0, io_en}, 32'd0);
        check("R1 mem_base", mem_base, 32'd0);
        rd(6'd1, 4'hF, "R1 cmdstat");
        rd(6'd4, 4'hF, "R1 bar");

        // R2: identity, little-endian, read-only
        rd(6'd0, 4'hF, "R2 ident");
        check("R2 vendor low", cfg_rdata[15:0], VEN);
        cyc(1'b1, 6'd0, 4'hF, 32'hFFFF_FFFF, 6'd0, "R2 write");
        rd(6'd0, 4'h1, "R2 ident lane0");
        rd(6'd0, 4'hF, "R2 ident after write");

        // R3: class/revision and header-type dword
        cyc(1'b1, 6'd2, 4'hF, 32'h0, 6'd0, "R3 write class");
        cyc(1'b1, 6'd3, 4'hF, 32'hFFFF_FFFF, 6'd0, "R3 write misc");
        rd(6'd2, 4'hF, "R3 class");
        rd(6'd3, 4'hF, "R3 header type");

        // R4: command writable mask and enables
        cyc(1'b1, 6'd1, 4'h3, 32'h0000_FFFF, 6'd0, "R4 cmd ones");
        rd(6'd1, 4'h3, "R4 cmd mask");
        check("R4 mem_en on", {31'd0, mem_en}, 32'd1);
        cyc(1'b1, 6'd1, 4'h1, 32'h0000_0001, 6'd0, "R4 mem off");
        check("R4 io only", {30'd0, mem_en, io_en}, 32'd1);

        // R5: lane-selective write and read
        cyc(1'b1, 6'd4, 4'h8, 32'hAB00_0000, 6'd0, "R5 bar lane3");
        rd(6'd4, 4'hF, "R5 bar byte3 only");
        cyc(1'b1, 6'd4, 4'h4, 32'h0000_0000, 6'd0, "R5 bar lane2");
        rd(6'd4, 4'h7, "R5 blank lane3");

        // R6: sticky flags, W1C, zero write, set-over-clear
        cyc(1'b0, 6'd0, 4'h0, 32'h0, 6'b111111, "R6 set all");
        rd(6'd1, 4'hC, "R6 all set");
        cyc(1'b1, 6'd1, 4'h8, 32'h0000_0000, 6'd0, "R6 write zero");
        rd(6'd1, 4'h8, "R6 zero no effect");
        cyc(1'b1, 6'd1, 4'h8, 32'h8100_0000, 6'd0, "R6 clear two");
        rd(6'd1, 4'h8, "R6 w1c");
        cyc(1'b1, 6'd1, 4'h8, 32'h4000_0000, 6'b010000, "R6 set vs clear");
        rd(6'd1, 4'h8, "R6 set wins");
        cyc(1'b1, 6'd1, 4'h7, 32'hFF00_0000, 6'd0, "R6 lane3 off");
        rd(6'd1, 4'h8, "R6 needs lane3");

        // R7: sizing
        cyc(1'b1, 6'd4, 4'hF, 32'hFFFF_FFFF, 6'd0, "R7 size write");
        rd(6'd4, 4'hF, "R7 size mask");
        check("R7 mask value", cfg_rdata, 32'hFFFF_F000);

        // R8: reserved header and device-specific area
        for (int i = 5; i < 64; i += 11) begin
            cyc(1'b1, i[5:0], 4'hF, 32'hFFFF_FFFF, 6'd0, "R8 reserved write");
            rd(i[5:0], 4'hF, "R8 reserved read");
        end
        cyc(1'b1, 6'h10, 4'hF, 32'hFFFF_FFFF, 6'd0, "R8 devspec write");
        rd(6'h10, 4'hF, "R8 devspec read");
        rd(6'd1, 4'h3, "R8 cmd kept");
        rd(6'd4, 4'hF, "R8 bar kept");

        // Random mix over all requirements
        for (int n = 0; n < 600; n++) begin
            logic [5:0]  idx;
            logic [3:0]  be;
            logic [31:0] wd;
            logic [5:0]  evt;
            idx = ($urandom % 4 == 0) ? 6'($urandom) : 6'($urandom % 6);
            be  = 4'($urandom);
            wd  = $urandom;
            evt = ($urandom % 6 == 0) ? 6'($urandom) : 6'd0;
            if ($urandom % 2 == 0)
                cyc(1'b1, idx, be, wd, evt, "R4 R5 R6 R7 random write");
            else
                rd(idx, be, "R2 R3 R5 R8 random read");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule